// File: doc/BRIEF.md
# Record Slot Directory

This block keeps the directory of a slot-organised record store. Each storage slot has a 64-bit entry that holds the identifier of the record stored in that slot, and an all-zeros entry marks a free slot. Beside the directory the block keeps a count of live records. Slots below a first data index hold the storage header and the directory itself, so no record can be placed there. Index 0 always lies in that reserved area, and the block uses it as the "not found" answer.

A client issues one request at a time with a single-cycle `req_valid` strobe. It then waits for the one-cycle `done` pulse, which carries a status, a slot index and, for the iterator, an identifier. The block offers six things:

- lookup of an identifier;
- allocation of the first free slot;
- clearing of an identifier;
- a direct write of an entry;
- a stateful iterator that walks the occupied slots and wraps at the end;
- an all-ones end marker returned by the iterator.

The directory sits in an internal array that the controller scans one entry per clock. Moving record payloads belongs to other logic.

Top module: `slot_dir`

## Requirements
- R1: After reset the block zeroes every directory entry, one per cycle. `busy` stays high during this sweep, `done` stays low and `rec_count` reads 0.
- R2: Operation codes on `req_op` are: 0 lookup, 1 allocate, 2 clear, 3 next, 4 assign. A request is taken only while `busy` is low. From then on `busy` stays high up to and including the single-cycle `done` pulse. A `req_valid` that arrives while `busy` is high is ignored.
- R3: Lookup returns status 0 (ok) and the index of the matching slot, searching from the first data index upward. When there is no match, or the identifier is all zeros, it returns index 0 and status 5 (not found).
- R4: Lookup stops as soon as it has passed as many occupied slots as `rec_count`. A lookup miss therefore spends one cycle on each slot from the first data index through the `rec_count`-th occupied slot, plus one final cycle.
- R5: Allocate returns the lowest slot at or above the first data index whose entry is zero, with status 0. When every slot is occupied it returns index 0 with status 1 (full). Allocate changes neither the directory nor the count.
- R6: Clear of an all-zeros or all-ones identifier returns status 3 (failed) and index 0. Clear of an identifier that is not present returns status 5 and index 0.
- R7: A successful clear zeroes the matching entry, decrements `rec_count`, and returns status 0 with the slot index.
- R8: Next starts at the first data index when `req_first` is 1, otherwise at the saved position. It returns the next occupied slot's identifier on `rsp_id` and its index on `rsp_idx`, and moves the saved position to just past that slot.
- R9: When next finds no further occupied slot, or `rec_count` is 0, it returns `rsp_id` all ones with index 0 and status 0, and resets the saved position to the first data index.
- R10: Assign writes `req_id` into slot `req_idx` and returns status 0 with that index. `rec_count` rises by one when a zero entry becomes nonzero, falls by one when a nonzero entry becomes zero, and is otherwise unchanged. An index at or beyond the last index is ignored and gives status 3.
- R11: The last index is the storage size divided by the slot size. The first data index is the header size plus eight bytes per slot, rounded up to whole slots. With the defaults these are 16 and 3.
- R12: Any other operation code returns status 3 and index 0. Operations other than next return `rsp_id` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 3 | Operation code |
| req_first | input | 1 | Restart the iterator at the first data index |
| req_idx | input | PW | Slot index for assign |
| req_id | input | ID_W | Identifier for lookup, clear and assign |
| busy | output | 1 | Sweep or request in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 3 | Result status |
| rsp_idx | output | PW | Result slot index, 0 meaning none |
| rsp_id | output | ID_W | Identifier returned by next |
| rec_count | output | PW | Number of live records |

## Verification
The early stop of a lookup cannot be seen in any result value, because the count always matches the directory. It shows only in latency. The bench therefore places records at scattered slots and times lookup misses before and after a clear. The expected cycle count comes from where the count-th occupied slot sits. A second hard case is the full directory, which the bench reaches by assigning every data slot in turn, including an overwrite that must leave the count unchanged.

// File: rtl/slot_dir_pkg.sv
package slot_dir_pkg;

  localparam logic [2:0] OP_LOOKUP = 3'd0;
  localparam logic [2:0] OP_ALLOC  = 3'd1;
  localparam logic [2:0] OP_CLEAR  = 3'd2;
  localparam logic [2:0] OP_NEXT   = 3'd3;
  localparam logic [2:0] OP_ASSIGN = 3'd4;

  localparam logic [2:0] ST_OK       = 3'd0;
  localparam logic [2:0] ST_FULL     = 3'd1;
  localparam logic [2:0] ST_FAILED   = 3'd3;
  localparam logic [2:0] ST_NOTFOUND = 3'd5;

  typedef enum logic [2:0] {
    S_INIT  = 3'd0,
    S_IDLE  = 3'd1,
    S_SCAN  = 3'd2,
    S_WRITE = 3'd3,
    S_RESP  = 3'd4
  } dir_state_e;

endpackage

// File: rtl/slot_dir_rst_sync.sv
module slot_dir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/slot_dir_ram.sv
module slot_dir_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/slot_dir_ctrl.sv
module slot_dir_ctrl
  import slot_dir_pkg::*;
#(
  parameter int LAST  = 16,
  parameter int FIRST = 3,
  parameter int ID_W  = 64,
  parameter int PW    = 5,
  parameter int AW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic            req_first,
  input  logic [PW-1:0]   req_idx,
  input  logic [ID_W-1:0] req_id,
  output logic            busy,
  output logic            done,
  output logic [2:0]      rsp_status,
  output logic [PW-1:0]   rsp_idx,
  output logic [ID_W-1:0] rsp_id,
  output logic [PW-1:0]   rec_count,
  output logic            ram_we,
  output logic [AW-1:0]   ram_waddr,
  output logic [ID_W-1:0] ram_wdata,
  output logic [AW-1:0]   ram_raddr,
  input  logic [ID_W-1:0] ram_rdata
);

  localparam logic [PW-1:0]   LAST_P  = PW'(LAST);
  localparam logic [PW-1:0]   FIRST_P = PW'(FIRST);
  localparam logic [PW-1:0]   TOP_P   = PW'(LAST - 1);
  localparam logic [PW-1:0]   ONE_P   = PW'(1);
  localparam logic [ID_W-1:0] ID_ZERO = '0;
  localparam logic [ID_W-1:0] ID_ONES = '1;

  dir_state_e      state_q, state_d;
  logic [2:0]      op_q, op_d;
  logic [ID_W-1:0] id_q, id_d;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic [PW-1:0]   seen_q, seen_d;
  logic [PW-1:0]   pos_q, pos_d;
  logic [PW-1:0]   cnt_q, cnt_d;
  logic [2:0]      st_q, st_d;
  logic [PW-1:0]   ridx_q, ridx_d;
  logic [ID_W-1:0] rid_q, rid_d;

  logic            at_end;
  logic            entry_used;
  logic [ID_W-1:0] entry;

  assign entry      = ram_rdata;
  assign at_end     = (ptr_q >= LAST_P);
  assign entry_used = (entry != ID_ZERO);

  always_comb begin
    state_d   = state_q;
    op_d      = op_q;
    id_d      = id_q;
    ptr_d     = ptr_q;
    seen_d    = seen_q;
    pos_d     = pos_q;
    cnt_d     = cnt_q;
    st_d      = st_q;
    ridx_d    = ridx_q;
    rid_d     = rid_q;
    ram_we    = 1'b0;
    ram_waddr = ptr_q[AW-1:0];
    ram_wdata = ID_ZERO;
    ram_raddr = ptr_q[AW-1:0];

    unique case (state_q)
      S_INIT: begin
        ram_we = 1'b1;
        ptr_d  = ptr_q + ONE_P;
        if (ptr_q == TOP_P) begin
          ptr_d   = '0;
          state_d = S_IDLE;
        end
      end

      S_IDLE: begin
        if (req_valid) begin
          op_d   = req_op;
          id_d   = req_id;
          ptr_d  = FIRST_P;
          seen_d = '0;
          ridx_d = '0;
          rid_d  = ID_ZERO;
          st_d   = ST_OK;
          case (req_op)
            OP_LOOKUP: begin
              if (req_id == ID_ZERO) begin
                st_d    = ST_NOTFOUND;
                state_d = S_RESP;
              end else begin
                state_d = S_SCAN;
              end
            end
            OP_ALLOC: state_d = S_SCAN;
            OP_CLEAR: begin
              if ((req_id == ID_ZERO) || (req_id == ID_ONES)) begin
                st_d    = ST_FAILED;
                state_d = S_RESP;
              end else begin
                state_d = S_SCAN;
              end
            end
            OP_NEXT: begin
              ptr_d = req_first ? FIRST_P : pos_q;
              if (cnt_q == '0) begin
                rid_d   = ID_ONES;
                pos_d   = FIRST_P;
                state_d = S_RESP;
              end else begin
                state_d = S_SCAN;
              end
            end
            OP_ASSIGN: begin
              if (req_idx >= LAST_P) begin
                st_d    = ST_FAILED;
                state_d = S_RESP;
              end else begin
                ptr_d   = req_idx;
                state_d = S_WRITE;
              end
            end
            default: begin
              st_d    = ST_FAILED;
              state_d = S_RESP;
            end
          endcase
        end
      end

      S_SCAN: begin
        case (op_q)
          OP_ALLOC: begin
            if (at_end) begin
              st_d    = ST_FULL;
              state_d = S_RESP;
            end else if (!entry_used) begin
              ridx_d  = ptr_q;
              state_d = S_RESP;
            end else begin
              ptr_d = ptr_q + ONE_P;
            end
          end
          OP_NEXT: begin
            if (at_end) begin
              rid_d   = ID_ONES;
              pos_d   = FIRST_P;
              state_d = S_RESP;
            end else if (entry_used) begin
              rid_d   = entry;
              ridx_d  = ptr_q;
              pos_d   = ptr_q + ONE_P;
              state_d = S_RESP;
            end else begin
              ptr_d = ptr_q + ONE_P;
            end
          end
          default: begin
            if (at_end || (seen_q >= cnt_q)) begin
              st_d    = ST_NOTFOUND;
              state_d = S_RESP;
            end else if (entry == id_q) begin
              ridx_d  = ptr_q;
              state_d = S_RESP;
              if (op_q == OP_CLEAR) begin
                ram_we = 1'b1;
                cnt_d  = cnt_q - ONE_P;
              end
            end else begin
              ptr_d = ptr_q + ONE_P;
              if (entry_used) begin
                seen_d = seen_q + ONE_P;
              end
            end
          end
        endcase
      end

      S_WRITE: begin
        ram_we    = 1'b1;
        ram_wdata = id_q;
        ridx_d    = ptr_q;
        if (!entry_used && (id_q != ID_ZERO)) begin
          cnt_d = cnt_q + ONE_P;
        end else if (entry_used && (id_q == ID_ZERO)) begin
          cnt_d = cnt_q - ONE_P;
        end
        state_d = S_RESP;
      end

      S_RESP: state_d = S_IDLE;

      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_INIT;
      op_q    <= OP_LOOKUP;
      id_q    <= '0;
      ptr_q   <= '0;
      seen_q  <= '0;
      pos_q   <= FIRST_P;
      cnt_q   <= '0;
      st_q    <= ST_OK;
      ridx_q  <= '0;
      rid_q   <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      id_q    <= id_d;
      ptr_q   <= ptr_d;
      seen_q  <= seen_d;
      pos_q   <= pos_d;
      cnt_q   <= cnt_d;
      st_q    <= st_d;
      ridx_q  <= ridx_d;
      rid_q   <= rid_d;
    end
  end

  assign busy       = (state_q != S_IDLE);
  assign done       = (state_q == S_RESP);
  assign rsp_status = st_q;
  assign rsp_idx    = ridx_q;
  assign rsp_id     = rid_q;
  assign rec_count  = cnt_q;

endmodule

// File: rtl/slot_dir.sv
module slot_dir #(
  parameter int STORE_BYTES = 1024,
  parameter int REC_BYTES   = 64,
  parameter int HDR_BYTES   = 24,
  parameter int ID_W        = 64,
  localparam int LAST_IDX   = STORE_BYTES / REC_BYTES,
  localparam int MAP_BYTES  = LAST_IDX * (ID_W / 8),
  localparam int FIRST_IDX  = (HDR_BYTES + MAP_BYTES + REC_BYTES - 1) / REC_BYTES,
  localparam int PW         = $clog2(LAST_IDX + 1),
  localparam int AW         = (LAST_IDX > 1) ? $clog2(LAST_IDX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic            req_first,
  input  logic [PW-1:0]   req_idx,
  input  logic [ID_W-1:0] req_id,
  output logic            busy,
  output logic            done,
  output logic [2:0]      rsp_status,
  output logic [PW-1:0]   rsp_idx,
  output logic [ID_W-1:0] rsp_id,
  output logic [PW-1:0]   rec_count
);

  logic            rst_n_sync;
  logic            ram_we;
  logic [AW-1:0]   ram_waddr;
  logic [AW-1:0]   ram_raddr;
  logic [ID_W-1:0] ram_wdata;
  logic [ID_W-1:0] ram_rdata;

  slot_dir_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  slot_dir_ram #(
    .DEPTH (LAST_IDX),
    .W     (ID_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  slot_dir_ctrl #(
    .LAST  (LAST_IDX),
    .FIRST (FIRST_IDX),
    .ID_W  (ID_W),
    .PW    (PW),
    .AW    (AW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_first  (req_first),
    .req_idx    (req_idx),
    .req_id     (req_id),
    .busy       (busy),
    .done       (done),
    .rsp_status (rsp_status),
    .rsp_idx    (rsp_idx),
    .rsp_id     (rsp_id),
    .rec_count  (rec_count),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .ram_raddr  (ram_raddr),
    .ram_rdata  (ram_rdata)
  );

endmodule

// File: rtl/slot_dir_chk.sv
module slot_dir_chk #(
  parameter int LAST = 16,
  parameter int PW   = 5,
  parameter int ID_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [2:0]      rsp_status,
  input logic [PW-1:0]   rsp_idx,
  input logic [ID_W-1:0] rsp_id,
  input logic [PW-1:0]   rec_count
);

  localparam logic [PW-1:0] ONE_P  = PW'(1);
  localparam logic [PW-1:0] LAST_P = PW'(LAST);

  p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_count_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(rec_count));

  p_notfound_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_status == 3'd5) |-> (rsp_idx == '0));

  p_full_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_status == 3'd1) |-> (rsp_idx == '0 && rsp_id == '0));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_count != $past(rec_count)) |->
      ((rec_count == $past(rec_count) + ONE_P) || (rec_count == $past(rec_count) - ONE_P)));

  p_end_marker_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_id == '1) |-> (rsp_idx == '0));

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= LAST_P);

endmodule

bind slot_dir slot_dir_chk #(
  .LAST (LAST_IDX),
  .PW   (PW),
  .ID_W (ID_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .rsp_status (rsp_status),
  .rsp_idx    (rsp_idx),
  .rsp_id     (rsp_id),
  .rec_count  (rec_count)
);

// File: tb/tb_slot_dir.sv
`timescale 1ns/1ps
module tb_slot_dir;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [2:0]  op;
    logic        first;
    logic [4:0]  idx;
    logic [63:0] id;
    logic [2:0]  est;
    logic [4:0]  eidx;
    logic [63:0] eid;
    logic [4:0]  ecnt;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{3'd3, 1'b1, 5'd0,  64'h0,    3'd0, 5'd0,  ONES,     5'd0}, // R9 empty store
    '{3'd0, 1'b0, 5'd0,  64'h11,   3'd5, 5'd0,  64'h0,    5'd0}, // R3 miss
    '{3'd1, 1'b0, 5'd0,  64'h0,    3'd0, 5'd3,  64'h0,    5'd0}, // R5 R11 first slot 3
    '{3'd4, 1'b0, 5'd3,  64'h11,   3'd0, 5'd3,  64'h0,    5'd1}, // R10 new entry
    '{3'd1, 1'b0, 5'd0,  64'h0,    3'd0, 5'd4,  64'h0,    5'd1}, // R5 skips used
    '{3'd4, 1'b0, 5'd7,  64'h22,   3'd0, 5'd7,  64'h0,    5'd2}, // R10
    '{3'd0, 1'b0, 5'd0,  64'h22,   3'd0, 5'd7,  64'h0,    5'd2}, // R3 hit
    '{3'd0, 1'b0, 5'd0,  64'h0,    3'd5, 5'd0,  64'h0,    5'd2}, // R3 zero id
    '{3'd3, 1'b1, 5'd0,  64'h0,    3'd0, 5'd3,  64'h11,   5'd2}, // R8 restart
    '{3'd3, 1'b0, 5'd0,  64'h0,    3'd0, 5'd7,  64'h22,   5'd2}, // R8 continue
    '{3'd3, 1'b0, 5'd0,  64'h0,    3'd0, 5'd0,  ONES,     5'd2}, // R9 end
    '{3'd3, 1'b0, 5'd0,  64'h0,    3'd0, 5'd3,  64'h11,   5'd2}, // R9 wrapped
    '{3'd2, 1'b0, 5'd0,  64'h0,    3'd3, 5'd0,  64'h0,    5'd2}, // R6 zero id
    '{3'd2, 1'b0, 5'd0,  ONES,     3'd3, 5'd0,  64'h0,    5'd2}, // R6 ones id
    '{3'd2, 1'b0, 5'd0,  64'h33,   3'd5, 5'd0,  64'h0,    5'd2}, // R6 absent
    '{3'd2, 1'b0, 5'd0,  64'h11,   3'd0, 5'd3,  64'h0,    5'd1}, // R7 success
    '{3'd0, 1'b0, 5'd0,  64'h11,   3'd5, 5'd0,  64'h0,    5'd1}, // R7 gone
    '{3'd4, 1'b0, 5'd16, 64'h44,   3'd3, 5'd0,  64'h0,    5'd1}, // R10 out of range
    '{3'd0, 1'b0, 5'd0,  64'h44,   3'd5, 5'd0,  64'h0,    5'd1}, // R10 not stored
    '{3'd1, 1'b0, 5'd0,  64'h0,    3'd0, 5'd3,  64'h0,    5'd1}, // R5 reuse freed
    '{3'd4, 1'b0, 5'd15, 64'h55,   3'd0, 5'd15, 64'h0,    5'd2}, // R10 top slot
    '{3'd3, 1'b1, 5'd0,  64'h0,    3'd0, 5'd7,  64'h22,   5'd2}, // R8
    '{3'd3, 1'b0, 5'd0,  64'h0,    3'd0, 5'd15, 64'h55,   5'd2}, // R8 last slot
    '{3'd3, 1'b0, 5'd0,  64'h0,    3'd0, 5'd0,  ONES,     5'd2}, // R9
    '{3'd7, 1'b0, 5'd0,  64'h0,    3'd3, 5'd0,  64'h0,    5'd2}  // R12 bad op
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic        req_first;
  logic [4:0]  req_idx;
  logic [63:0] req_id;
  logic        busy;
  logic        done;
  logic [2:0]  rsp_status;
  logic [4:0]  rsp_idx;
  logic [63:0] rsp_id;
  logic [4:0]  rec_count;

  int n_chk;
  int n_bad;
  int lat;

  slot_dir dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_first  (req_first),
    .req_idx    (req_idx),
    .req_id     (req_id),
    .busy       (busy),
    .done       (done),
    .rsp_status (rsp_status),
    .rsp_idx    (rsp_idx),
    .rsp_id     (rsp_id),
    .rec_count  (rec_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [2:0] op, input logic first,
                         input logic [4:0] idx, input logic [63:0] id);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_first = first;
    req_idx   = idx;
    req_id    = id;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int wait_cyc;
    bit saw_done;
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_op = 3'd0;
    req_first = 1'b0;
    req_idx = '0;
    req_id = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b1, "R1 busy during sweep", 64'(busy), 64'd1);
    check(rec_count == 5'd0, "R1 count", 64'(rec_count), 64'd0);
    wait_cyc = 0;
    saw_done = 1'b0;
    while (busy && wait_cyc < 40) begin
      if (done) saw_done = 1'b1;
      @(negedge clk);
      wait_cyc++;
    end
    check(wait_cyc >= 16 && wait_cyc < 40, "R1 sweep length", 64'(wait_cyc), 64'd17);
    check(!saw_done, "R1 no done in sweep", 64'(saw_done), 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i].op, VEC[i].first, VEC[i].idx, VEC[i].id);
      check(rsp_status == VEC[i].est && rsp_idx == VEC[i].eidx &&
            rsp_id == VEC[i].eid && rec_count == VEC[i].ecnt,
            $sformatf("R2 vector %0d status/idx/cnt", i),
            {rsp_id[39:0], 5'd0, rsp_status, 3'd0, rsp_idx, 3'd0, rec_count},
            {VEC[i].eid[39:0], 5'd0, VEC[i].est, 3'd0, VEC[i].eidx, 3'd0, VEC[i].ecnt});
    end

    // R4 miss with records at 7 and 15: scans slots 3..15 plus one cycle
    run_req(3'd0, 1'b0, 5'd0, 64'h99);
    check(lat == 14 && rsp_status == 3'd5, "R4 miss latency two records", 64'(lat), 64'd14);
    run_req(3'd2, 1'b0, 5'd0, 64'h55);
    check(rec_count == 5'd1, "R7 clear top slot", 64'(rec_count), 64'd1);
    // R4 only slot 7 occupied: stops after slot 7
    run_req(3'd0, 1'b0, 5'd0, 64'h99);
    check(lat == 6 && rsp_status == 3'd5, "R4 early stop latency", 64'(lat), 64'd6);

    // R2 a request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd0; req_id = 64'h99;
    @(posedge clk);
    @(negedge clk);
    req_op = 3'd4; req_idx = 5'd4; req_id = 64'h77;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    saw_done = 1'b0;
    repeat (3) begin
      @(negedge clk);
      if (done) saw_done = 1'b1;
    end
    check(!saw_done, "R2 no extra done", 64'(saw_done), 64'd0);
    check(rec_count == 5'd1, "R2 ignored assign count", 64'(rec_count), 64'd1);
    run_req(3'd0, 1'b0, 5'd0, 64'h77);
    check(rsp_status == 3'd5, "R2 ignored assign absent", 64'(rsp_status), 64'd5);

    // R5 fill every data slot
    for (int s = 3; s < 16; s++) begin
      run_req(3'd4, 1'b0, 5'(s), 64'h100 + 64'(s));
    end
    check(rec_count == 5'd13, "R10 overwrite keeps count", 64'(rec_count), 64'd13);
    run_req(3'd1, 1'b0, 5'd0, 64'h0);
    check(rsp_status == 3'd1 && rsp_idx == 5'd0, "R5 full", 64'(rsp_status), 64'd1);
    run_req(3'd0, 1'b0, 5'd0, 64'h10F);
    check(rsp_status == 3'd0 && rsp_idx == 5'd15, "R3 hit in full store", 64'(rsp_idx), 64'd15);
    run_req(3'd4, 1'b0, 5'd3, 64'h0);
    check(rec_count == 5'd12, "R10 zeroing decrements", 64'(rec_count), 64'd12);
    run_req(3'd1, 1'b0, 5'd0, 64'h0);
    check(rsp_status == 3'd0 && rsp_idx == 5'd3, "R5 R11 freed slot", 64'(rsp_idx), 64'd3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule